// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block controls a successive-approximation analog-to-digital converter on behalf of a CPU. Software sees a single 8-bit control/status register holding an enable bit, a start/busy bit, an auto-trigger enable, a completion flag, an interrupt enable and a 3-bit clock divider code. The block divides the system clock into an ADC clock and counts ADC clock cycles through each conversion. The conversion result is taken from an input word that stands in for the analog comparator and the DAC.

A conversion can start in three ways. Software can write the start bit. With auto-trigger on, a rising edge on the trigger input can start it. In free-running mode, each completed conversion is followed at once by the next one. At the end of a conversion the result word is latched into a read-only data output and the completion flag is set. An interrupt request is raised when the flag, the interrupt enable and the CPU's global interrupt enable are all set. Clearing the enable bit stops a conversion that is in progress.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register bit reads 0, the data output is 0 and the interrupt line is low. The register layout is fixed as follows: bit 7 enable, bit 6 start/busy, bit 5 auto-trigger enable, bit 4 completion flag, bit 3 interrupt enable, bits 2:0 divider code.
- R2: A normal conversion lasts 13 ADC clock cycles. The first conversion after the enable bit goes from 0 to 1 lasts 25 ADC clock cycles. This also holds when start is written in the same write that sets enable.
- R3: The start bit reads 1 from the cycle after a start is accepted until the conversion completes, and then returns to 0. Writing 0 to the start bit has no effect. A start write is accepted only if the same write also sets the enable bit.
- R4: A write that clears the enable bit stops any conversion in progress. The start bit reads 0 afterwards, the data output keeps its previous value and the flag is not set.
- R5: With auto-trigger on and free-running mode off, each rising edge of the trigger input starts one conversion. A trigger input that stays high starts nothing further.
- R6: On completion, the data output takes the value of the result input in the final ADC cycle and the flag is set. The flag is cleared by a register write with bit 4 set, or by the acknowledge input. Writing 0 to bit 4 leaves it unchanged. If a completion and a clear fall in the same cycle, the completion wins.
- R7: The interrupt output is high exactly while the flag, the interrupt enable bit and the global-enable input are all 1.
- R8: With auto-trigger on and the free-running input high, a new conversion begins in the same cycle that the previous one completes, so successive completions are exactly 13 ADC clock periods apart. The start bit stays 1 throughout.
- R9: Divider codes 0 to 7 give ADC clock periods of 2, 2, 4, 8, 16, 32, 64 and 128 system clocks.
- R10: The divider counter is held at zero while the unit is disabled. As a result, a conversion started by the write that enables the unit completes exactly 25 times the divider period after that write.
- R11: A start write or a trigger edge that arrives while a conversion is in progress is ignored. It neither restarts the current conversion nor queues another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| trig_in | input | 1 | Auto-trigger source |
| free_run | input | 1 | Selects free-running restart when auto-trigger is on |
| gie | input | 1 | CPU global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| conv_result | input | 10 | Result word from the converter datapath |
| data_out | output | 10 | Latched conversion result |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
The assertions check several rules on every cycle: a disabling write always leaves the unit idle and sets no flag, writing 0 to start never ends a running conversion, the cycle counter stays inside the length allowed for the current kind of conversion, every completion updates the data and the flag together, and the divider counter sits at zero while disabled. Some behaviour can only be shown by the bench scenarios: exact conversion lengths for each divider code, the extra length of the first conversion, edge versus level triggering, back-to-back timing in free-running mode, ignored starts that leave no queued conversion, and the gating of the interrupt by its three enables.

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
  parameter int RES_W    = 10,
  parameter int PS_W     = 3,
  parameter int NORM_CYC = 13,
  parameter int INIT_CYC = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             trig_in,
  input  logic             free_run,
  input  logic             gie,
  input  logic             irq_ack,
  input  logic [RES_W-1:0] conv_result,
  output logic [RES_W-1:0] data_out,
  output logic             irq
);
  localparam int CNT_W = (1 << PS_W) - 1;
  localparam int TC_W  = $clog2(INIT_CYC);
  localparam logic [TC_W-1:0] LAST_INIT = TC_W'(INIT_CYC - 1);
  localparam logic [TC_W-1:0] LAST_NORM = TC_W'(NORM_CYC - 1);

  logic            en, ate, flag, ie, busy, init_pend, trig_q;
  logic [PS_W-1:0] ps;
  logic [CNT_W-1:0] pcnt, mask;
  logic [TC_W-1:0] tcnt;
  logic            tick, wr_dis, sw_go, hw_go, go, last, done, restart;

  assign mask    = (ps < PS_W'(2)) ? CNT_W'(1) : ((CNT_W'(1) << ps) - CNT_W'(1));
  assign tick    = en && ((pcnt & mask) == mask);
  assign wr_dis  = reg_wr && !reg_wdata[7];
  assign sw_go   = reg_wr && reg_wdata[7] && reg_wdata[6];
  assign hw_go   = en && ate && !free_run && trig_in && !trig_q && !wr_dis;
  assign go      = !busy && (sw_go || hw_go);
  assign last    = tcnt == (init_pend ? LAST_INIT : LAST_NORM);
  assign done    = busy && tick && last && !wr_dis;
  assign restart = done && ate && free_run;

  assign reg_rdata = {en, busy, ate, flag, ie, ps};
  assign irq       = flag && ie && gie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; ate <= 1'b0; ie <= 1'b0; ps <= '0;
    end else if (reg_wr) begin
      en  <= reg_wdata[7];
      ate <= reg_wdata[5];
      ie  <= reg_wdata[3];
      ps  <= reg_wdata[PS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) pcnt <= '0;
    else               pcnt <= pcnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      busy <= 1'b0;
    else if (wr_dis)                 busy <= 1'b0;
    else if (go)                     busy <= 1'b1;
    else if (done && !restart)       busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              tcnt <= '0;
    else if (go || done)     tcnt <= '0;
    else if (busy && tick)   tcnt <= tcnt + TC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                init_pend <= 1'b0;
    else if (reg_wr && reg_wdata[7] && !en)    init_pend <= 1'b1;
    else if (done)                             init_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  flag <= 1'b0;
    else if (done)                               flag <= 1'b1;
    else if ((reg_wr && reg_wdata[4]) || irq_ack) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    data_out <= '0;
    else if (done) data_out <= conv_result;
  end

  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> !busy);
  assert_abort_noflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dis && !flag) |=> !flag);
  assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && reg_wr && reg_wdata[7] && !reg_wdata[6]) |=> busy);
  assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tcnt <= (init_pend ? LAST_INIT : LAST_NORM)));
  assert_done_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (flag && data_out == $past(conv_result)));
  assert_ps_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pcnt == '0));
endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  logic clk = 0, rst_n = 0, reg_wr = 0, trig_in = 0, free_run = 0, gie = 0, irq_ack = 0;
  logic [7:0] reg_wdata = 0;
  logic [9:0] conv_result = 0;
  wire  [7:0] reg_rdata;
  wire  [9:0] data_out;
  wire        irq;

  adc_seq_ctrl uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trig_in(trig_in), .free_run(free_run), .gie(gie),
    .irq_ack(irq_ack), .conv_result(conv_result), .data_out(data_out), .irq(irq));

  always #2 clk = ~clk;

  typedef struct { logic [9:0] res; int lo; int hi; string req; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0, start_cyc = 0;
  bit auto_ack = 1, prev_busy = 0, prev_flag = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic push(input logic [9:0] r, input int lo, input int hi, input string req);
    exp_t e;
    e.res = r; e.lo = lo; e.hi = hi; e.req = req;
    q.push_back(e);
  endtask

  function automatic int dv(input int code);
    return (code < 2) ? 2 : (1 << code);
  endfunction

  task automatic wait_idle;
    do @(negedge clk); while (reg_rdata[6]);
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (auto_ack && irq_ack) irq_ack = 0;
      if (reg_rdata[6] && !prev_busy) start_cyc = cyc;
      if (reg_rdata[4] && !prev_flag) begin
        if (q.size() == 0) chk(0, "R11", "unexpected completion", cyc, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(data_out == e.res, e.req, "result", int'(data_out), int'(e.res));
          chk((cyc - start_cyc) >= e.lo && (cyc - start_cyc) <= e.hi, e.req,
              "duration", cyc - start_cyc, e.hi);
        end
        if (reg_rdata[6]) start_cyc = cyc;
        if (auto_ack) irq_ack = 1;
      end
      prev_busy = reg_rdata[6];
      prev_flag = reg_rdata[4];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WD", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R1", "register after reset", int'(reg_rdata), 0);
    chk(data_out == 0, "R1", "data after reset", int'(data_out), 0);
    chk(irq == 0, "R1", "irq after reset", int'(irq), 0);

    // R10 / R2: enable and start in one write, divider 8, first conversion exactly 25*8
    conv_result = 10'h2A5;
    push(10'h2A5, 25 * 8, 25 * 8, "R10");
    wr(8'hC3);
    chk(reg_rdata[6] == 1, "R3", "busy after start", int'(reg_rdata[6]), 1);
    chk(reg_rdata[7] == 1, "R1", "enable bit", int'(reg_rdata[7]), 1);
    wait_idle();
    chk(reg_rdata[6] == 0, "R3", "busy after completion", int'(reg_rdata[6]), 0);

    // R2 normal length, R3 write of zero, R11 start while busy
    conv_result = 10'h155;
    push(10'h155, 12 * 8 + 1, 13 * 8, "R2");
    wr(8'hC3);
    repeat (20) @(negedge clk);
    wr(8'h83);
    chk(reg_rdata[6] == 1, "R3", "start=0 write kept busy", int'(reg_rdata[6]), 1);
    wr(8'hC3);
    wait_idle();
    repeat (30) @(negedge clk);
    chk(reg_rdata[6] == 0, "R11", "no queued conversion", int'(reg_rdata[6]), 0);
    chk(q.size() == 0, "R11", "pending items", q.size(), 0);

    // R4 abort
    conv_result = 10'h0F0;
    wr(8'hC3);
    repeat (40) @(negedge clk);
    wr(8'h03);
    chk(reg_rdata[6] == 0, "R4", "busy after disable", int'(reg_rdata[6]), 0);
    repeat (300) @(negedge clk);
    chk(data_out == 10'h155, "R4", "data kept", int'(data_out), 10'h155);
    chk(reg_rdata[4] == 0, "R4", "flag after abort", int'(reg_rdata[4]), 0);

    // R9 divider codes
    conv_result = 10'h011;
    push(10'h011, 25 * 32, 25 * 32, "R9");
    wr(8'hC5);
    wait_idle();
    conv_result = 10'h022;
    push(10'h022, 12 * dv(7) + 1, 13 * dv(7), "R9");
    wr(8'hC7);
    wait_idle();
    conv_result = 10'h033;
    push(10'h033, 12 * dv(1) + 1, 13 * dv(1), "R9");
    wr(8'hC1);
    wait_idle();
    conv_result = 10'h044;
    push(10'h044, 12 * dv(0) + 1, 13 * dv(0), "R9");
    wr(8'hC0);
    wait_idle();
    conv_result = 10'h055;
    push(10'h055, 12 * dv(6) + 1, 13 * dv(6), "R9");
    wr(8'hC6);
    wait_idle();

    // R7 / R6 interrupt gating and flag clearing
    auto_ack = 0;
    conv_result = 10'h3C3;
    push(10'h3C3, 97, 104, "R6");
    wr(8'hCB);
    wait_idle();
    chk(reg_rdata[4] == 1, "R6", "flag set", int'(reg_rdata[4]), 1);
    chk(irq == 0, "R7", "irq with gie low", int'(irq), 0);
    gie = 1;
    @(negedge clk);
    chk(irq == 1, "R7", "irq with all enables", int'(irq), 1);
    wr(8'h83);
    chk(irq == 0, "R7", "irq with ie low", int'(irq), 0);
    chk(reg_rdata[4] == 1, "R6", "flag after writing 0", int'(reg_rdata[4]), 1);
    wr(8'h93);
    chk(reg_rdata[4] == 0, "R6", "flag after writing 1", int'(reg_rdata[4]), 0);
    conv_result = 10'h0AA;
    push(10'h0AA, 97, 104, "R6");
    wr(8'hCB);
    wait_idle();
    chk(irq == 1, "R7", "irq after second completion", int'(irq), 1);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk(reg_rdata[4] == 0, "R6", "flag after acknowledge", int'(reg_rdata[4]), 0);
    chk(irq == 0, "R7", "irq after acknowledge", int'(irq), 0);
    auto_ack = 1;
    gie = 0;

    // R5 trigger edge, R11 edge while busy
    wr(8'hA3);
    conv_result = 10'h101;
    push(10'h101, 97, 104, "R5");
    @(negedge clk); trig_in = 1;
    repeat (30) @(negedge clk);
    trig_in = 0; @(negedge clk); trig_in = 1;
    wait_idle();
    repeat (150) @(negedge clk);
    chk(reg_rdata[6] == 0, "R5", "level holds no new conversion", int'(reg_rdata[6]), 0);
    chk(q.size() == 0, "R11", "edge while busy ignored", q.size(), 0);
    trig_in = 0; @(negedge clk);
    conv_result = 10'h202;
    push(10'h202, 97, 104, "R5");
    trig_in = 1;
    wait_idle();
    trig_in = 0;

    // R8 free-running
    free_run = 1;
    conv_result = 10'h3FF;
    push(10'h3FF, 97, 104, "R8");
    push(10'h3FF, 104, 104, "R8");
    push(10'h3FF, 104, 104, "R8");
    wr(8'hE3);
    while (q.size() > 1) @(negedge clk);
    chk(reg_rdata[6] == 1, "R8", "busy held between runs", int'(reg_rdata[6]), 1);
    wr(8'h83);
    wait_idle();
    free_run = 0;
    repeat (200) @(negedge clk);
    chk(q.size() == 0, "R8", "completions outstanding", q.size(), 0);
    chk(reg_rdata[6] == 0, "R8", "stopped after auto-trigger off", int'(reg_rdata[6]), 0);
    summary();
  end
endmodule